// File: doc/BRIEF.md
# Decade 1-2-5 Sample Clock Generator

This block derives a sample strobe for a data acquisition front end from a fixed system clock. A 4-bit rate selector picks one of sixteen sample rates. The rates step through a 1-2-5 progression in each decade, from 1 Hz up to 100 kHz. Each strobe is a single system-clock-wide pulse on `tick`. The consumer starts one set of simultaneous conversions per strobe.

A second mode feeds an external sample clock straight through without any division. The external pin is brought into the system clock domain by a multi-stage synchronizer. One strobe is produced for every rising edge seen on the synchronized pin.

A new rate selection never cuts short a period that is already running, so no runt interval and no doubled strobe can appear. Leaving external mode restarts the internal divider from a full period.

Top module: `sample_tick_gen`

## Requirements
- R1: Rate code c (0..15) selects the rate m·10^(c/3) Hz, where m is 1, 2 or 5 for c mod 3 equal to 0, 1 or 2. In internal mode the distance between strobes is max(1, floor(SYS_CLK_HZ / rate)) system clock cycles.
- R2: In internal mode, for any rate whose spacing is at least 2 cycles, each strobe is high for exactly one cycle.
- R3: A rate code change takes effect at a strobe. The interval already in progress completes with the old spacing, and the next interval uses the new spacing.
- R4: With `ext_sel`=1, exactly one strobe is produced for each rising edge of `ext_clk`. The strobes are spaced exactly as the external edges are, with no division.
- R5: In external mode, falling edges and steady levels of `ext_clk` produce no strobe, and strobes never occur in two consecutive cycles.
- R6: With `ext_sel`=0, activity on `ext_clk` has no effect on the strobe spacing.
- R7: With `ext_sel`=1, the internal divider produces no strobe, even at the fastest rate code.
- R8: When `ext_sel` falls, the first internal strobe appears exactly one full spacing of the current code after the first clock edge with `ext_sel`=0.
- R9: While `rst` is high, `tick` is 0. After `rst` falls, the first strobe appears one full spacing of the current code after the first clock edge with `rst`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of frequency SYS_CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 4 | Rate selector on the 1-2-5 ladder |
| ext_sel | input | 1 | 1 selects the external sample clock, 0 the internal divider |
| ext_clk | input | 1 | Asynchronous external sample clock pin |
| tick | output | 1 | Registered single-cycle sample strobe |

## Verification
The assertions check the following on every cycle:
- the divider count always stays below its latched period;
- the latched period changes only at a wrap or while the divider is held;
- every strobe traces back either to a divider wrap or to a synchronized rising edge, depending on the mode;
- synchronized edges never arrive back to back.

Only the bench scenarios can show that the absolute spacing matches the 1-2-5 ladder for each code, and that a code change lands exactly one interval late. They also show that strobe counts match external edge counts, and that restarts after reset or after leaving external mode take a full period.

// File: rtl/stg_pkg.sv
package stg_pkg;

  localparam int RATE_CODE_W = 4;
  localparam int NUM_RATES   = 1 << RATE_CODE_W;

  // Rate on the 1-2-5 ladder for a given code, in Hz.
  function automatic longint ladder_hz(input int code);
    longint r;
    case (code % 3)
      0:       r = 1;
      1:       r = 2;
      default: r = 5;
    endcase
    for (int d = 0; d < code / 3; d++) r = r * 10;
    return r;
  endfunction

  // Cycles between strobes; never below one.
  function automatic longint spacing_cycles(input longint sys_hz, input int code);
    longint s;
    s = sys_hz / ladder_hz(code);
    if (s < 1) s = 1;
    return s;
  endfunction

endpackage

// File: rtl/stg_rate_rom.sv
module stg_rate_rom
  import stg_pkg::*;
#(
  parameter longint SYS_CLK_HZ = 125_000_000,
  parameter int     CNT_W      = 27
) (
  input  logic [RATE_CODE_W-1:0] code,
  output logic [CNT_W-1:0]       period
);

  logic [CNT_W-1:0] table_q [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_entry
    assign table_q[g] = CNT_W'(spacing_cycles(SYS_CLK_HZ, g));
  end

  assign period = table_q[code];

endmodule

// File: rtl/stg_divider.sv
module stg_divider #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [CNT_W-1:0] period,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= period - CNT_W'(1);
      per_q <= period;
    end else if (cnt_q == '0) begin
      cnt_q <= period - CNT_W'(1);
      per_q <= period;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign wrap = (cnt_q == '0) && !hold;

  // R1: the running count never reaches the period it was loaded from
  p_count_below_period_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q < per_q);

  // R3: a new period is only taken on at a wrap or while held
  p_period_latched_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && cnt_q != '0) |=> (hold || $stable(per_q)));

endmodule

// File: rtl/stg_edge_sync.sv
module stg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] && !last_q;

  // R5: a detected edge is never followed by another in the next cycle
  p_rise_isolated_r5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/sample_tick_gen.sv
module sample_tick_gen
  import stg_pkg::*;
#(
  parameter longint SYS_CLK_HZ  = 125_000_000,
  parameter int     SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RATE_CODE_W-1:0] rate_code,
  input  logic                   ext_sel,
  input  logic                   ext_clk,
  output logic                   tick
);

  localparam int CNT_W = $clog2(SYS_CLK_HZ + 1);

  logic [CNT_W-1:0] period;
  logic             int_wrap;
  logic             ext_rise;

  stg_rate_rom #(.SYS_CLK_HZ(SYS_CLK_HZ), .CNT_W(CNT_W)) rom_i (
    .code   (rate_code),
    .period (period)
  );

  stg_divider #(.CNT_W(CNT_W)) div_i (
    .clk    (clk),
    .rst    (rst),
    .hold   (ext_sel),
    .period (period),
    .wrap   (int_wrap)
  );

  stg_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_clk),
    .rise (ext_rise)
  );

  always_ff @(posedge clk) begin
    if (rst)          tick <= 1'b0;
    else if (ext_sel) tick <= ext_rise;
    else              tick <= int_wrap;
  end

  // R4: an external-mode strobe comes from a synchronized rising edge
  p_ext_tick_from_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && $past(ext_sel)) |-> $past(ext_rise));

  // R7: an internal-mode strobe comes from a divider wrap
  p_int_tick_from_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && !$past(ext_sel)) |-> $past(int_wrap));

  // R9: no strobe leaves the reset cycle
  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tick);

endmodule

// File: tb/sample_tick_gen_tb_top.sv
module sample_tick_gen_tb_top;

  localparam longint SYS_HZ = 20_000;
  localparam int     WATCHDOG = 180_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rate_code = 4'd15;
  logic       ext_sel = 1'b0;
  logic       ext_clk = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sample_tick_gen #(.SYS_CLK_HZ(SYS_HZ), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .rate_code (rate_code),
    .ext_sel   (ext_sel),
    .ext_clk   (ext_clk),
    .tick      (tick)
  );

  function automatic int exp_gap(input int code);
    longint hz;
    longint g;
    hz = (code % 3 == 0) ? 1 : (code % 3 == 1) ? 2 : 5;
    for (int i = 0; i < code / 3; i++) hz = hz * 10;
    g = SYS_HZ / hz;
    return (g < 1) ? 1 : int'(g);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until tick is seen high; call from a negedge.
  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 60_000);
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1;
    rate_code = 4'd7;
    ext_sel = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 tick low in reset", int'(tick), 0);
    end
    rst = 1'b0;
    gap(n);
    check("R9 first tick after reset", n, exp_gap(7));
  endtask

  task automatic t_code_scan();
    int n;
    int prev;
    rate_code = 4'd15;
    gap(n);
    gap(n);
    check("R1 code 15 spacing", n, exp_gap(15));
    prev = 15;
    for (int c = 14; c >= 0; c--) begin
      rate_code = 4'(c);
      gap(n);
      check($sformatf("R3 old spacing kept, code %0d->%0d", prev, c), n, exp_gap(prev));
      gap(n);
      check($sformatf("R1 spacing code %0d", c), n, exp_gap(c));
      if (exp_gap(c) >= 2) begin
        @(negedge clk);
        check($sformatf("R2 one-cycle strobe code %0d", c), int'(tick), 0);
        gap(n);
        check($sformatf("R2 spacing after width check code %0d", c), n, exp_gap(c) - 1);
      end
      prev = c;
    end
  endtask

  task automatic t_ext_ignored();
    int n;
    rate_code = 4'd6;
    gap(n);
    gap(n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n % 3 == 0) ext_clk = ~ext_clk;
    end while (!tick && n < 60_000);
    check("R6 ext pin ignored in internal mode", n, exp_gap(6));
    ext_clk = 1'b0;
  endtask

  task automatic t_ext_mode();
    int ticks = 0;
    int last = -1;
    int back2back = 0;
    int bad_gap = 0;
    ext_clk = 1'b0;
    @(negedge clk);
    ext_sel = 1'b1;
    rate_code = 4'd15;
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      if (tick) begin
        ticks++;
        if (last == i - 1) back2back++;
        if (last >= 0 && i - last != 20) bad_gap++;
        last = i;
      end
      if (i < 120) ext_clk = ((i % 20) < 10);
      else         ext_clk = 1'b0;
    end
    check("R4 one tick per rising edge", ticks, 6);
    check("R4 undivided edge spacing", bad_gap, 0);
    check("R5 no consecutive ext ticks", back2back, 0);
  endtask

  task automatic t_int_blocked();
    int ticks = 0;
    ext_clk = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i > 8 && tick) ticks++;
    end
    check("R7 internal divider silent, level high", ticks, 0);
    ext_clk = 1'b0;
    ticks = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i > 8 && tick) ticks++;
    end
    check("R5 falling edge and low level give no tick", ticks, 0);
  endtask

  task automatic t_return_internal();
    int n;
    rate_code = 4'd5;
    @(negedge clk);
    ext_sel = 1'b0;
    gap(n);
    check("R8 full period after leaving ext mode", n, exp_gap(5));
    gap(n);
    check("R8 steady spacing after return", n, exp_gap(5));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_code_scan();
    t_ext_ignored();
    t_ext_mode();
    t_int_blocked();
    t_return_internal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule